// File: doc/BRIEF.md
# Multi-Event Word Packing Buffer

This block sits between a producer of zero-suppressed 16-bit words and a host that reads 32-bit words. It keeps up to `NSLOT` (default 16) complete events in separate slots. The producer opens an event, streams its 16-bit words and closes it. Meanwhile the host drains older events in the order they were closed. When the host reads an event, it first gets a header halfword. The header carries the slot number and the event's total halfword count. The host sees two halfwords per 32-bit read, with the earlier halfword in the low half.

A clear pulse that arrives while the clear window input is high throws away the event being written. Its slot is then reused by the next event. When every slot holds an unread event, `busy` rises and new event starts are refused. A slot is freed when the host reads the last word of its event. Each slot holds at most `MAX_DATA` data halfwords. Words beyond that limit are dropped.

Top module: `mwpb_event_buffer`

## Requirements
- R1: After reset, `rd_empty` is 1 and `busy` is 0.
- R2: A `wr_start` pulse while no event is open and `busy` is low opens an event. The event starts taking data one cycle later. Each cycle with `wr_valid` high while the event is open stores `wr_data` in order. `wr_valid` has no effect while no event is open.
- R3: The first halfword of every event is a header.
  - Bits 15:12 hold the slot number.
  - Bits 11:10 are 0.
  - Bits 9:0 hold the total halfword count: the header plus the stored data words.
- R4: Packed word k of an event carries halfword 2k in bits 15:0 and halfword 2k+1 in bits 31:16.
- R5: When the total count is odd, bits 31:16 of the event's final packed word are 16'hFFFF. `rd_last` is 1 exactly while that final word is shown.
- R6: While `rd_empty` is 0, `rd_data` shows the current packed word. The word stays stable until a `rd_strobe` cycle, which advances to the next word, or to the next event after the last word. A `rd_strobe` while `rd_empty` is 1 has no effect.
- R7: Slot numbers are handed out cyclically from 0 after reset, one per closed event. Events are read back in the order they were closed.
- R8: With `NSLOT` closed, unread events, `busy` is 1. A `wr_start`, data and `wr_end` during that time create no event. Reading out an event clears `busy`.
- R9: `fclr` high while `fcw` is high and an event is open discards that event. This takes priority over a `wr_end` in the same cycle, and the next event reuses the slot. `fclr` with `fcw` low has no effect.
- R10: Data words beyond `MAX_DATA` in one event are dropped, so the total count saturates at `MAX_DATA`+1.
- R11: When an event closes in the same cycle that the host retires another event, both take effect: the closed event is readable afterwards.
- R12: `wr_end` may come in the same cycle as the final `wr_valid`, and that word is included in the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Open a new event |
| wr_valid | input | 1 | Data halfword strobe |
| wr_data | input | 16 | Data halfword |
| wr_end | input | 1 | Close the open event |
| fcw | input | 1 | Clear window |
| fclr | input | 1 | Clear pulse, effective only inside the window |
| busy | output | 1 | All slots hold unread events |
| rd_strobe | input | 1 | Host consumes the shown word |
| rd_data | output | 32 | Packed word shown to the host |
| rd_last | output | 1 | Shown word is the last of its event |
| rd_empty | output | 1 | No closed event is waiting |

## Verification
Two functions can land in the same cycle: a write-side event close and a read-side event retirement. Both change the occupancy count. The bench provokes this by driving `wr_end` for one event and a `rd_strobe` on the last word of an earlier event at the same falling edge. It then checks that the buffer is not empty and that the new event's header appears next. A second collision, a window clear together with `wr_end`, is judged by the buffer staying empty and by the following event reusing the slot number.

// File: rtl/mwpb_pkg.sv
package mwpb_pkg;
  localparam int HDR_SLOT_W = 4;
  localparam int HDR_CNT_W  = 10;
  localparam logic [15:0] FILL_HALF = 16'hFFFF;

  // header halfword: slot in the top nibble, total count in the low ten bits
  function automatic logic [15:0] hdr_make(input logic [HDR_SLOT_W-1:0] slot,
                                           input logic [HDR_CNT_W-1:0] total);
    return {slot, 2'b00, total};
  endfunction

  // number of 32-bit words needed for a given halfword count
  function automatic logic [HDR_CNT_W-1:0] words32(input logic [HDR_CNT_W-1:0] total);
    return (total + 10'd1) >> 1;
  endfunction
endpackage

// File: rtl/mwpb_slot_q.sv
module mwpb_slot_q #(
  parameter int NSLOT = 16,
  localparam int SW = $clog2(NSLOT),
  localparam int CW = $clog2(NSLOT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          retire,
  output logic [SW-1:0] wr_ptr,
  output logic [SW-1:0] rd_ptr,
  output logic          full,
  output logic          empty
);
  logic [CW-1:0] count;

  function automatic logic [SW-1:0] nxt(input logic [SW-1:0] p);
    return (p == SW'(NSLOT - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (commit) wr_ptr <= nxt(wr_ptr);
      if (retire) rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(commit) - CW'(retire);
    end
  end

  assign full  = (count == CW'(NSLOT));
  assign empty = (count == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) full |-> !commit); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) empty |-> !retire); // R6
  AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && retire) |=> (count == $past(count))); // R11
endmodule

// File: rtl/mwpb_wr_ctrl.sv
module mwpb_wr_ctrl #(
  parameter int MAX_DATA = 6,
  localparam int LW = $clog2(MAX_DATA + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  logic          wr_valid,
  input  logic [15:0]   wr_data,
  input  logic          wr_end,
  input  logic          fcw,
  input  logic          fclr,
  input  logic          full,
  output logic          open,
  output logic          mem_we,
  output logic [LW-1:0] mem_idx,
  output logic [15:0]   mem_din,
  output logic          commit,
  output logic [9:0]    commit_total
);
  logic [LW-1:0] len;
  logic kill;

  assign kill         = open & fcw & fclr;
  assign mem_we       = open & wr_valid & ~kill & (len < LW'(MAX_DATA));
  assign mem_idx      = len;
  assign mem_din      = wr_data;
  assign commit       = open & wr_end & ~kill;
  assign commit_total = 10'(len) + 10'(mem_we) + 10'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open <= 1'b0;
      len  <= '0;
    end else if (!open) begin
      if (wr_start && !full) begin
        open <= 1'b1;
        len  <= '0;
      end
    end else if (kill || commit) begin
      open <= 1'b0;
    end else if (mem_we) begin
      len <= len + 1'b1;
    end
  end

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n) kill |=> !open); // R9
  AST_FULL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) full |-> !open); // R8
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n) len <= LW'(MAX_DATA)); // R10
endmodule

// File: rtl/mwpb_store.sv
module mwpb_store #(
  parameter int NSLOT = 16,
  parameter int MAX_DATA = 6,
  localparam int SW = $clog2(NSLOT),
  localparam int LW = $clog2(MAX_DATA + 1)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [SW-1:0] wslot,
  input  logic [LW-1:0] widx,
  input  logic [15:0]   wdin,
  input  logic          tot_we,
  input  logic [9:0]    tot_din,
  input  logic [SW-1:0] rslot,
  input  logic [LW-1:0] ra,
  input  logic [LW-1:0] rb,
  output logic [15:0]   qa,
  output logic [15:0]   qb,
  output logic [9:0]    rtot
);
  logic [15:0] mem [NSLOT][MAX_DATA];
  logic [9:0]  tot [NSLOT];

  always_ff @(posedge clk) begin
    if (we) mem[wslot][widx] <= wdin;
    if (tot_we) tot[wslot] <= tot_din;
  end

  assign qa   = (ra < LW'(MAX_DATA)) ? mem[rslot][ra] : '0;
  assign qb   = (rb < LW'(MAX_DATA)) ? mem[rslot][rb] : '0;
  assign rtot = tot[rslot];
endmodule

// File: rtl/mwpb_rd_pack.sv
module mwpb_rd_pack
  import mwpb_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int MAX_DATA = 6,
  localparam int SW = $clog2(NSLOT),
  localparam int LW = $clog2(MAX_DATA + 1),
  localparam int PW = $clog2(MAX_DATA + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_strobe,
  input  logic          empty,
  input  logic [SW-1:0] rd_ptr,
  input  logic [9:0]    tot,
  input  logic [15:0]   qa,
  input  logic [15:0]   qb,
  output logic [LW-1:0] ra,
  output logic [LW-1:0] rb,
  output logic [31:0]   rd_data,
  output logic          rd_last,
  output logic          retire
);
  logic [PW-1:0] pos;
  logic [9:0] h_lo, h_hi;
  logic [15:0] lo_half, hi_half;
  logic step;

  assign h_lo = 10'(pos) << 1;
  assign h_hi = h_lo + 10'd1;
  assign ra   = LW'(h_lo - 10'd1);
  assign rb   = LW'(h_hi - 10'd1);

  assign lo_half = (h_lo == 10'd0) ? hdr_make(HDR_SLOT_W'(rd_ptr), tot) : qa;
  assign hi_half = (h_hi < tot) ? qb : FILL_HALF;
  assign rd_data = {hi_half, lo_half};

  assign rd_last = (10'(pos) == words32(tot) - 10'd1);
  assign step    = rd_strobe & ~empty;
  assign retire  = step & rd_last;

  always_ff @(posedge clk) begin
    if (!rst_n)      pos <= '0;
    else if (retire) pos <= '0;
    else if (step)   pos <= pos + 1'b1;
  end

  AST_FRESH_EVENT: assert property (@(posedge clk) disable iff (!rst_n) retire |=> (pos == '0)); // R6
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !rd_strobe) |=> $stable(rd_data)); // R6
  AST_HEAD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && pos == '0) |-> (rd_data[15:12] == HDR_SLOT_W'(rd_ptr))); // R3
endmodule

// File: rtl/mwpb_event_buffer.sv
module mwpb_event_buffer #(
  parameter int NSLOT = 16,
  parameter int MAX_DATA = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_start,
  input  logic        wr_valid,
  input  logic [15:0] wr_data,
  input  logic        wr_end,
  input  logic        fcw,
  input  logic        fclr,
  output logic        busy,
  input  logic        rd_strobe,
  output logic [31:0] rd_data,
  output logic        rd_last,
  output logic        rd_empty
);
  localparam int SW = $clog2(NSLOT);
  localparam int LW = $clog2(MAX_DATA + 1);

  logic [SW-1:0] wr_ptr, rd_ptr;
  logic full, empty, open, commit, retire, mem_we;
  logic [LW-1:0] mem_idx, ra, rb;
  logic [15:0] mem_din, qa, qb;
  logic [9:0] commit_total, tot;

  mwpb_slot_q #(.NSLOT(NSLOT)) u_q (
    .clk(clk), .rst_n(rst_n), .commit(commit), .retire(retire),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .empty(empty));

  mwpb_wr_ctrl #(.MAX_DATA(MAX_DATA)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_end(wr_end), .fcw(fcw), .fclr(fclr), .full(full),
    .open(open), .mem_we(mem_we), .mem_idx(mem_idx), .mem_din(mem_din),
    .commit(commit), .commit_total(commit_total));

  mwpb_store #(.NSLOT(NSLOT), .MAX_DATA(MAX_DATA)) u_st (
    .clk(clk), .we(mem_we), .wslot(wr_ptr), .widx(mem_idx), .wdin(mem_din),
    .tot_we(commit), .tot_din(commit_total), .rslot(rd_ptr), .ra(ra), .rb(rb),
    .qa(qa), .qb(qb), .rtot(tot));

  mwpb_rd_pack #(.NSLOT(NSLOT), .MAX_DATA(MAX_DATA)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .empty(empty),
    .rd_ptr(rd_ptr), .tot(tot), .qa(qa), .qb(qb), .ra(ra), .rb(rb),
    .rd_data(rd_data), .rd_last(rd_last), .retire(retire));

  assign busy     = full;
  assign rd_empty = empty;

  AST_START_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_start) |=> !open); // R8
  AST_BUSY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && retire) |=> !busy); // R8
endmodule

// File: tb/mwpb_event_buffer_test.sv
module mwpb_event_buffer_test;
  localparam int NSLOT = 16;
  localparam int MAXD  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_start = 0, wr_valid = 0, wr_end = 0, fcw = 0, fclr = 0, rd_strobe = 0;
  logic [15:0] wr_data = '0;
  logic busy, rd_last, rd_empty;
  logic [31:0] rd_data;

  int vectors = 0;
  int miscompares = 0;
  int wslot = 0;
  logic [31:0] expq[$];
  logic lastq[$];

  always #2.5 clk = ~clk;

  mwpb_event_buffer #(.NSLOT(NSLOT), .MAX_DATA(MAXD)) uut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_end(wr_end), .fcw(fcw), .fclr(fclr), .busy(busy),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_last(rd_last), .rd_empty(rd_empty));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected packed words for an accepted event
  task automatic model_commit(input logic [15:0] d[$]);
    logic [15:0] hw[$];
    int stored = (d.size() > MAXD) ? MAXD : d.size();
    int total = stored + 1;
    hw.push_back({4'(wslot), 2'b00, 10'(total)});
    for (int i = 0; i < stored; i++) hw.push_back(d[i]);
    if (total % 2 == 1) hw.push_back(16'hFFFF);
    for (int k = 0; k < hw.size() / 2; k++) begin
      expq.push_back({hw[2*k+1], hw[2*k]});
      lastq.push_back(k == hw.size() / 2 - 1);
    end
    wslot = (wslot + 1) % NSLOT;
  endtask

  task automatic send_ev(input int n, input bit merge, input bit accepted, input logic [15:0] seed);
    logic [15:0] d[$];
    @(negedge clk) wr_start = 1;
    @(negedge clk) wr_start = 0;
    for (int i = 0; i < n; i++) begin
      wr_valid = 1;
      wr_data = 16'(seed + i * 37);
      d.push_back(wr_data);
      if (merge && i == n - 1) wr_end = 1;
      @(negedge clk);
    end
    wr_valid = 0;
    if (!(merge && n > 0)) begin
      wr_end = 1;
      @(negedge clk);
    end
    wr_end = 0;
    if (accepted) model_commit(d);
  endtask

  task automatic drain(input string req);
    while (!rd_empty) begin
      if (expq.size() == 0) begin
        chk(req, 32'(rd_empty), 32'd1);
        break;
      end
      chk(req, rd_data, expq.pop_front());
      chk(req, 32'(rd_last), 32'(lastq.pop_front()));
      rd_strobe = 1;
      @(negedge clk);
      rd_strobe = 0;
    end
    chk(req, 32'(expq.size()), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] d[$];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 empty", 32'(rd_empty), 32'd1);
    chk("R1 busy", 32'(busy), 32'd0);

    // R6: strobe on empty buffer must not skip the next header
    rd_strobe = 1; @(negedge clk); rd_strobe = 0;
    // R2: stray data with no event open is ignored
    wr_valid = 1; wr_data = 16'hDEAD; @(negedge clk); wr_valid = 0;
    chk("R2 stray data", 32'(rd_empty), 32'd1);

    // R2 R3 R4 R5 R10 R12: sweep of lengths, merged end on odd lengths
    for (int n = 0; n <= MAXD + 2; n++) begin
      send_ev(n, n % 2 == 1, 1, 16'(16'h1000 * n + 5));
      drain("R4 sweep");
    end

    // R7 R8: fill every slot, slot numbers wrap
    for (int e = 0; e < NSLOT; e++) begin
      chk("R8 not busy yet", 32'(busy), 32'd0);
      send_ev(e % 4, 0, 1, 16'(16'h0A00 + e));
    end
    chk("R8 busy", 32'(busy), 32'd1);
    send_ev(3, 0, 0, 16'h7777);
    chk("R8 refused", 32'(busy), 32'd1);
    // R8: read one event frees a slot
    chk("R7 order", rd_data, expq.pop_front());
    chk("R5 last", 32'(rd_last), 32'(lastq.pop_front()));
    rd_strobe = 1; @(negedge clk); rd_strobe = 0;
    chk("R8 freed", 32'(busy), 32'd0);
    drain("R7 drain");
    chk("R8 empty after drain", 32'(rd_empty), 32'd1);

    // R9: clear inside window discards
    @(negedge clk) wr_start = 1;
    @(negedge clk) wr_start = 0; wr_valid = 1; wr_data = 16'h1111;
    @(negedge clk) wr_valid = 0; fcw = 1; fclr = 1;
    @(negedge clk) fclr = 0; wr_end = 1;
    @(negedge clk) wr_end = 0; fcw = 0;
    @(negedge clk);
    chk("R9 discarded", 32'(rd_empty), 32'd1);
    // R9: clear outside window has no effect
    d.delete();
    @(negedge clk) wr_start = 1;
    @(negedge clk) wr_start = 0; wr_valid = 1; wr_data = 16'h2222; d.push_back(16'h2222);
    @(negedge clk) wr_valid = 0; fclr = 1;
    @(negedge clk) fclr = 0; wr_end = 1;
    @(negedge clk) wr_end = 0;
    model_commit(d);
    drain("R9 no window");
    // R9: clear beats end in the same cycle
    @(negedge clk) wr_start = 1;
    @(negedge clk) wr_start = 0; wr_valid = 1; wr_data = 16'h3333;
    @(negedge clk) wr_valid = 0; fcw = 1; fclr = 1; wr_end = 1;
    @(negedge clk) fcw = 0; fclr = 0; wr_end = 0;
    @(negedge clk);
    chk("R9 clear wins", 32'(rd_empty), 32'd1);
    send_ev(2, 0, 1, 16'h4400);
    drain("R9 slot reuse");

    // R11: close and retire in the same cycle
    send_ev(0, 0, 1, 16'h0);
    d.delete();
    @(negedge clk) wr_start = 1;
    @(negedge clk) wr_start = 0; wr_valid = 1; wr_data = 16'h5150; d.push_back(16'h5150);
    @(negedge clk) wr_data = 16'h5151; d.push_back(16'h5151);
    @(negedge clk) wr_valid = 0; wr_end = 1; rd_strobe = 1;
    chk("R11 prior word", rd_data, expq.pop_front());
    chk("R11 prior last", 32'(rd_last), 32'(lastq.pop_front()));
    @(negedge clk) wr_end = 0; rd_strobe = 0;
    model_commit(d);
    chk("R11 not empty", 32'(rd_empty), 32'd0);
    drain("R11 new event");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule